// File: doc/BRIEF.md
# Four-Channel Multi-Mode Counter/Timer

This block holds four independent 16-bit counter/timer channels. All four share one input prescaler that divides the system clock by a programmable ratio. Each channel is set up through a small word-wide register port. A channel can count up or down and runs in one of five modes: one-shot pulse, repeating waveform, event counting, time capture, or watchdog.

Each channel has a gate input and a trigger input. Each of these comes in two copies: one fed from on-chip programmable logic and one fed straight from a device pin. A control bit in each channel picks which copy the channel uses. When a channel reaches its terminal value it emits a one-cycle terminal-count pulse, which goes to an interrupt controller. A second per-channel output carries the pulse or waveform level.

Software writes the reload value first and then the control word. Writing the control word loads the counter and starts the channel. Count and capture values can be read back at any time.

Top module: `ctu_top`

## Requirements
- R1: After reset, every count, capture, reload and control register reads 0, the prescale register reads 4, and all `tc_o` and `wave_o` bits are low.
- R2: The prescale register sits at address 0x20 and stores 9 bits. The ratio in effect is the stored value limited to the range 4..280. Writing the register restarts the prescaler phase. A running, gated, non-event channel advances exactly once per ratio-in-effect clock cycles.
- R3: Channel c owns addresses c*8+k, with k = 0 control, 1 reload, 2 count (read), 3 capture (read), 4 kick (write), 5 status (bit 0 = timeout). Control bits are [2:0] mode (0 pulse, 1 waveform, 2 event, 3 capture, 4 watchdog), [3] up, [4] pin source, [5] run. Control and reload read back what was written. A control write loads the count from reload and clears timeout.
- R4: Counting goes up (control bit 3 = 1) or down. The terminal value is 0xFFFF up and 0x0000 down. `tc_o` is a single-cycle pulse in the cycle the count becomes the terminal value. Event and capture counts wrap past the terminal value.
- R5: Pulse mode counts from reload to the terminal value once and then stops. `wave_o` is high while the shot is running. A rising trigger with run set reloads and restarts the shot.
- R6: Waveform mode reloads from the reload register on the step after reaching the terminal value and toggles `wave_o` at each terminal count. With reload 1 counting down and ratio 4, there is one terminal count every 8 cycles.
- R7: Event mode advances once per rising edge of the selected trigger while the selected gate is high, independent of the prescaler.
- R8: In capture mode, a rising trigger copies the count held at that clock edge into the capture register.
- R9: Watchdog mode always counts down, whatever the up bit says. A kick write reloads the count. Reaching zero pulses `tc_o`, stops the count and sets a timeout flag. The flag survives kicks and clears only on a control write.
- R10: With control bit 4 = 1 a channel uses only `gate_pin_i`/`trig_pin_i`; with 0 it uses only `gate_arr_i`/`trig_arr_i`. The inputs that are not selected have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Write address |
| wdata_i | input | 16 | Write data |
| rd_addr_i | input | 6 | Read address |
| rdata_o | output | 16 | Combinational read data |
| gate_arr_i | input | 4 | Per-channel gate from programmable logic |
| gate_pin_i | input | 4 | Per-channel gate from pins |
| trig_arr_i | input | 4 | Per-channel trigger from programmable logic |
| trig_pin_i | input | 4 | Per-channel trigger from pins |
| tc_o | output | 4 | Per-channel terminal-count pulse |
| wave_o | output | 4 | Per-channel pulse/waveform level |

## Verification
The assertions assume that gate and trigger inputs are synchronous to `clk`. They also assume that a trigger stays low for at least one cycle between rising edges; this is what keeps event-mode terminal counts one cycle wide. The bench drives all inputs at falling edges and builds every trigger as one high cycle followed by at least one low cycle. It starts a channel only after the reload value has been written. It brings any value it needs to time precisely through capture differences taken a whole number of prescale periods apart, so the prescaler phase never enters an expected value.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int CW     = 16;
  localparam int PW     = 9;
  localparam int PMIN   = 4;
  localparam int PMAX   = 280;
  localparam int CTRL_W = 6;

  localparam logic [2:0] RG_CTRL   = 3'd0;
  localparam logic [2:0] RG_RELOAD = 3'd1;
  localparam logic [2:0] RG_COUNT  = 3'd2;
  localparam logic [2:0] RG_CAPT   = 3'd3;
  localparam logic [2:0] RG_KICK   = 3'd4;
  localparam logic [2:0] RG_STAT   = 3'd5;

  typedef enum logic [2:0] {
    M_PULSE = 3'd0,
    M_WAVE  = 3'd1,
    M_EVENT = 3'd2,
    M_CAPT  = 3'd3,
    M_WDOG  = 3'd4
  } mode_e;

  typedef struct packed {
    logic  run;
    logic  src_pin;
    logic  up;
    mode_e mode;
  } ctrl_t;

  function automatic logic [PW-1:0] clamp_ratio(input logic [PW-1:0] r);
    if (r < PW'(PMIN)) return PW'(PMIN);
    if (r > PW'(PMAX)) return PW'(PMAX);
    return r;
  endfunction

  function automatic logic [CW-1:0] step_val(input logic [CW-1:0] v, input logic up);
    return up ? v + CW'(1) : v - CW'(1);
  endfunction

  function automatic logic [CW-1:0] term_of(input logic up);
    return up ? {CW{1'b1}} : {CW{1'b0}};
  endfunction
endpackage

// File: rtl/ctu_prescaler.sv
module ctu_prescaler
  import ctu_pkg::*;
#(
  parameter int RW = PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_i,
  input  logic          restart_i,
  output logic          tick_o
);
  logic [RW-1:0] eff;
  logic [RW-1:0] cnt_q;

  assign eff    = clamp_ratio(ratio_i);
  assign tick_o = (cnt_q == eff - RW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + RW'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < eff);
endmodule

// File: rtl/ctu_channel.sv
module ctu_channel
  import ctu_pkg::*;
#(
  parameter int W = CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ctrl_wr_i,
  input  logic              reload_wr_i,
  input  logic              kick_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              gate_arr_i,
  input  logic              gate_pin_i,
  input  logic              trig_arr_i,
  input  logic              trig_pin_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [W-1:0]      reload_o,
  output logic [W-1:0]      count_o,
  output logic [W-1:0]      capture_o,
  output logic              timeout_o,
  output logic              tc_o,
  output logic              wave_o
);
  ctrl_t        ctrl_q;
  logic [W-1:0] reload_q, count_q, capt_q, nxt, new_val, term;
  logic         active_q, timeout_q, tc_q, wave_q, trig_q;
  logic         gate, trig, trig_rise, up_eff, step, retrig, kick, hit, capt_ev;

  assign gate      = ctrl_q.src_pin ? gate_pin_i : gate_arr_i;
  assign trig      = ctrl_q.src_pin ? trig_pin_i : trig_arr_i;
  assign trig_rise = trig & ~trig_q;
  assign up_eff    = (ctrl_q.mode == M_WDOG) ? 1'b0 : ctrl_q.up;
  assign term      = term_of(up_eff);
  assign nxt       = step_val(count_q, up_eff);
  assign new_val   = (ctrl_q.mode == M_WAVE && count_q == term) ? reload_q : nxt;
  assign step      = active_q & gate & ((ctrl_q.mode == M_EVENT) ? trig_rise : tick_i);
  assign retrig    = trig_rise && ctrl_q.mode == M_PULSE && ctrl_q.run;
  assign kick      = kick_i && ctrl_q.mode == M_WDOG && ctrl_q.run;
  assign hit       = step && (new_val == term) && !ctrl_wr_i && !retrig && !kick;
  assign capt_ev   = trig_rise && ctrl_q.mode == M_CAPT && active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      count_q   <= '0;
      capt_q    <= '0;
      active_q  <= 1'b0;
      timeout_q <= 1'b0;
      tc_q      <= 1'b0;
      wave_q    <= 1'b0;
      trig_q    <= 1'b0;
    end else begin
      trig_q <= trig;
      tc_q   <= hit;
      if (reload_wr_i) reload_q <= wdata_i;
      if (capt_ev) capt_q <= count_q;
      if (ctrl_wr_i) begin
        ctrl_q    <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        count_q   <= reload_q;
        active_q  <= wdata_i[CTRL_W-1];
        timeout_q <= 1'b0;
        wave_q    <= 1'b0;
      end else if (retrig || kick) begin
        count_q  <= reload_q;
        active_q <= 1'b1;
      end else if (step) begin
        count_q <= new_val;
        if (hit) begin
          if (ctrl_q.mode == M_PULSE || ctrl_q.mode == M_WDOG) active_q <= 1'b0;
          if (ctrl_q.mode == M_WDOG) timeout_q <= 1'b1;
          if (ctrl_q.mode == M_WAVE) wave_q <= ~wave_q;
        end
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;
  assign count_o   = count_q;
  assign capture_o = capt_q;
  assign timeout_o = timeout_q;
  assign tc_o      = tc_q;
  assign wave_o    = (ctrl_q.mode == M_PULSE) ? active_q : wave_q;

  // R4
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);
  // R4
  tc_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> (count_q == term));
  // R8
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capt_ev |=> (capt_q == $past(count_q)));
  // R9
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_q && !ctrl_wr_i) |=> timeout_q);
  // R5
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mode == M_PULSE && !active_q && !ctrl_wr_i && !retrig) |=> $stable(count_q));
endmodule

// File: rtl/ctu_top.sv
module ctu_top
  import ctu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CW-1:0]  wdata_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [CW-1:0]  rdata_o,
  input  logic [NCH-1:0] gate_arr_i,
  input  logic [NCH-1:0] gate_pin_i,
  input  logic [NCH-1:0] trig_arr_i,
  input  logic [NCH-1:0] trig_pin_i,
  output logic [NCH-1:0] tc_o,
  output logic [NCH-1:0] wave_o
);
  localparam int SW = AW - 3;
  localparam logic [AW-1:0] PRE_ADDR = AW'(NCH * 8);

  logic [PW-1:0]     ratio_q;
  logic              pre_wr, tick;
  logic [CTRL_W-1:0] ctrl_a   [NCH];
  logic [CW-1:0]     reload_a [NCH];
  logic [CW-1:0]     count_a  [NCH];
  logic [CW-1:0]     capt_a   [NCH];
  logic [NCH-1:0]    tmo_a;

  assign pre_wr = wr_en_i && (addr_i == PRE_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      ratio_q <= PW'(PMIN);
    else if (pre_wr) ratio_q <= wdata_i[PW-1:0];
  end

  ctu_prescaler #(.RW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio_q), .restart_i(pre_wr), .tick_o(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (addr_i[AW-1:3] == SW'(i));
    ctu_channel #(.W(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .ctrl_wr_i(sel && addr_i[2:0] == RG_CTRL),
      .reload_wr_i(sel && addr_i[2:0] == RG_RELOAD),
      .kick_i(sel && addr_i[2:0] == RG_KICK),
      .wdata_i(wdata_i),
      .gate_arr_i(gate_arr_i[i]), .gate_pin_i(gate_pin_i[i]),
      .trig_arr_i(trig_arr_i[i]), .trig_pin_i(trig_pin_i[i]),
      .ctrl_o(ctrl_a[i]), .reload_o(reload_a[i]), .count_o(count_a[i]),
      .capture_o(capt_a[i]), .timeout_o(tmo_a[i]),
      .tc_o(tc_o[i]), .wave_o(wave_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_addr_i == PRE_ADDR) rdata_o = CW'(ratio_q);
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr_i[AW-1:3] == SW'(i)) begin
        case (rd_addr_i[2:0])
          RG_CTRL:   rdata_o = CW'(ctrl_a[i]);
          RG_RELOAD: rdata_o = reload_a[i];
          RG_COUNT:  rdata_o = count_a[i];
          RG_CAPT:   rdata_o = capt_a[i];
          RG_STAT:   rdata_o = CW'(tmo_a[i]);
          default:   rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/sim_ctu_top.sv
module sim_ctu_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0, rd_addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  ga = '0, gp = '0, ta = '0, tp = '0, tc, wave;

  always #(CLK_P/2) clk = ~clk;

  ctu_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rd_addr_i(rd_addr), .rdata_o(rdata), .gate_arr_i(ga), .gate_pin_i(gp),
    .trig_arr_i(ta), .trig_pin_i(tp), .tc_o(tc), .wave_o(wave)
  );

  typedef struct {
    logic [5:0]  a;
    logic [15:0] e;
    bit          cmp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  item_t       it;
  logic [15:0] fetched;
  int          total = 0, bad = 0, cyc = 0;
  int          tcc[4] = '{0, 0, 0, 0};
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) for (int k = 0; k < 4; k++) if (tc[k]) tcc[k]++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      rd_addr = it.a;
      #1;
      if (it.cmp) chk(32'(rdata), 32'(it.e), it.tag);
      else fetched = rdata;
    end
  end

  function automatic logic [5:0] ra(input int ch, input int r);
    return 6'(ch * 8 + r);
  endfunction

  task automatic expect_rd(input logic [5:0] a, input logic [15:0] e, input string tag);
    item_t x;
    x.a = a; x.e = e; x.cmp = 1'b1; x.tag = tag;
    sb_q.push_back(x);
    wait (sb_q.size() == 0);
    #2;
  endtask

  task automatic fetch(input logic [5:0] a);
    item_t x;
    x.a = a; x.e = '0; x.cmp = 1'b0; x.tag = "";
    sb_q.push_back(x);
    wait (sb_q.size() == 0);
    #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig(input bit pin, input int ch);
    @(negedge clk);
    if (pin) tp[ch] = 1'b1; else ta[ch] = 1'b1;
    @(negedge clk);
    if (pin) tp[ch] = 1'b0; else ta[ch] = 1'b0;
  endtask

  // capture difference across d edges on channel ch
  task automatic span(input int ch, input int d, input int exp, input bit down, input string tag);
    int t0;
    logic [15:0] c1, diff;
    @(negedge clk);
    t0 = cyc;
    ta[ch] = 1'b1;
    @(negedge clk);
    ta[ch] = 1'b0;
    fetch(ra(ch, 3));
    c1 = fetched;
    while (cyc < t0 + d) @(negedge clk);
    ta[ch] = 1'b1;
    @(negedge clk);
    ta[ch] = 1'b0;
    fetch(ra(ch, 3));
    diff = down ? c1 - fetched : fetched - c1;
    chk(32'(diff), 32'(exp), tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int t, w;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(32'(tc), 0, "R1 tc");
    chk(32'(wave), 0, "R1 wave");
    expect_rd(6'h20, 16'd4, "R1 ratio");
    expect_rd(ra(0, 2), 16'h0, "R1 count");
    expect_rd(ra(2, 3), 16'h0, "R1 capture");
    expect_rd(ra(1, 0), 16'h0, "R1 ctrl");
    ga = 4'hF;

    // R5 pulse, down, reload 3
    wr(ra(0, 1), 16'd3);
    wr(ra(0, 0), 16'h20);
    chk(32'(wave[0]), 1, "R5 wave while running");
    expect_rd(ra(0, 1), 16'd3, "R3 reload readback");
    expect_rd(ra(0, 0), 16'h20, "R3 ctrl readback");
    idle(60);
    chk(tcc[0], 1, "R5 one tc");
    chk(32'(wave[0]), 0, "R5 wave after shot");
    expect_rd(ra(0, 2), 16'h0, "R4 down stops at 0");
    pulse_trig(1'b0, 0);
    idle(60);
    chk(tcc[0], 2, "R5 retrigger tc");
    // R4 up terminal
    wr(ra(0, 1), 16'hFFFD);
    wr(ra(0, 0), 16'h28);
    idle(60);
    expect_rd(ra(0, 2), 16'hFFFF, "R4 up stops at FFFF");
    chk(tcc[0], 3, "R4 up tc");

    // R6 waveform, ch1 reload 1 down
    wr(ra(1, 1), 16'd1);
    wr(ra(1, 0), 16'h21);
    idle(20);
    t = tcc[1]; w = int'(wave[1]);
    idle(80);
    chk(tcc[1] - t, 10, "R6 tc per 80 cycles");
    chk(32'(wave[1]), 32'(w), "R6 even toggles");
    idle(8);
    chk(32'(wave[1]), 32'(w ^ 1), "R6 toggle per tc");

    // R2 / R8 capture on ch2, up
    wr(ra(2, 1), 16'd0);
    wr(ra(2, 0), 16'h2B);
    wr(6'h20, 16'd1);
    span(2, 40, 10, 1'b0, "R2 clamp low R8");
    wr(6'h20, 16'd300);
    expect_rd(6'h20, 16'd300, "R2 raw ratio stored");
    span(2, 560, 2, 1'b0, "R2 clamp high");
    wr(6'h20, 16'd10);
    span(2, 50, 5, 1'b0, "R2 ratio 10");
    // R4 down capture
    wr(6'h20, 16'd4);
    wr(ra(2, 1), 16'd1000);
    wr(ra(2, 0), 16'h23);
    span(2, 40, 10, 1'b1, "R4 down count");

    // R7 / R10 event on ch3, pin source
    ga[3] = 1'b0;
    gp[3] = 1'b1;
    wr(ra(3, 1), 16'd0);
    wr(ra(3, 0), 16'h3A);
    for (int k = 0; k < 3; k++) pulse_trig(1'b1, 3);
    expect_rd(ra(3, 2), 16'd3, "R7 three events");
    ga[3] = 1'b1;
    pulse_trig(1'b0, 3);
    pulse_trig(1'b0, 3);
    expect_rd(ra(3, 2), 16'd3, "R10 array trig ignored");
    gp[3] = 1'b0;
    pulse_trig(1'b1, 3);
    expect_rd(ra(3, 2), 16'd3, "R7 gate low blocks");
    wr(ra(3, 1), 16'hFFFE);
    wr(ra(3, 0), 16'h2A);
    pulse_trig(1'b0, 3);
    idle(1);
    expect_rd(ra(3, 2), 16'hFFFF, "R4 event reaches FFFF");
    chk(tcc[3], 1, "R4 event tc");
    pulse_trig(1'b0, 3);
    expect_rd(ra(3, 2), 16'h0, "R4 event wrap");

    // R9 watchdog on ch0, up bit set but ignored
    wr(ra(0, 1), 16'd5);
    wr(ra(0, 0), 16'h2C);
    t = tcc[0];
    for (int k = 0; k < 10; k++) begin
      idle(10);
      wr(ra(0, 4), 16'h0);
    end
    expect_rd(ra(0, 5), 16'h0, "R9 kicked no timeout");
    chk(tcc[0] - t, 0, "R9 no tc while kicked");
    idle(60);
    expect_rd(ra(0, 5), 16'h1, "R9 timeout set");
    expect_rd(ra(0, 2), 16'h0, "R9 count at zero");
    chk(tcc[0] - t, 1, "R9 single tc");
    wr(6'h20, 16'd280);
    wr(ra(0, 4), 16'h0);
    expect_rd(ra(0, 2), 16'd5, "R9 kick reloads");
    expect_rd(ra(0, 5), 16'h1, "R9 timeout sticky");
    wr(ra(0, 0), 16'h2C);
    expect_rd(ra(0, 5), 16'h0, "R3 ctrl write clears timeout");

    summary();
  end
endmodule